// File: doc/BRIEF.md
# Bus Target Transaction Controller

This block is the target side of a 32-bit parallel bus on which address and data share the same wires and every control line is active low. On each rising clock it samples the transaction-start strobe, the initiator-ready strobe, the command/byte-enable lines and the shared address/data lines. When a transaction starts, it registers the address and command. In the next cycle it decodes them against a fixed, naturally aligned memory window. If the access hits the window, the block claims it. It then moves data between the bus and a small register file that holds one 32-bit word per word of the window.

Writes are accepted from the first cycle after the claim. Reads leave one idle cycle on the shared lines first, so that the lines can change direction. A read burst therefore takes one cycle longer than the same write burst. A burst may run for at most a configured number of data phases. On the last allowed phase, the target raises its stop and ready strobes together. That phase transfers its data, and the target then takes no more. If the initiator makes the target wait too long in a data phase, the block raises a protocol-error flag. The flag stays set until the next address phase.

Top module: `bus_target_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `devsel_n`, `trdy_n` and `stop_n` are 1, and `ad_oe` and `proto_err` are 0.
- R2: A transaction whose command on `cbe_n` in the address phase is 4'b0110 (memory read) or 4'b0111 (memory write), and whose address lies in the 16-byte window at `WIN_BASE`, is claimed. `devsel_n` is 0 from the second cycle after the address cycle, which is within the three-cycle limit.
- R3: Any other command, or a memory command outside the window, is never claimed. `devsel_n`, `trdy_n` and `stop_n` stay 1, and no register-file word changes.
- R4: On a write, `trdy_n` goes to 0 in the same cycle as `devsel_n`. A data phase completes on each rising edge where `irdy_n` and `trdy_n` are both 0. `trdy_n` is never 0 while `devsel_n` is 1.
- R5: On a read, the cycle after the claim is a turnaround cycle, with `ad_oe` at 0 and `trdy_n` at 1. From the third cycle after the address cycle, `ad_oe` is 1, `trdy_n` is 0 and `ad_out` carries the addressed word.
- R6: A completed write phase updates exactly the bytes whose `cbe_n` bit is 0. Bit i of `cbe_n` enables bits 8i+7..8i of the data.
- R7: Address bits 1..0 are ignored. Bits 3..2 select the word. Each completed phase of a burst advances to the next word, and the word index wraps inside the window.
- R8: On data phase number `MAX_BURST` (default 3) of a transaction, `stop_n` goes to 0 in the same cycle as `trdy_n`. That phase transfers its data. Afterwards `trdy_n` is 1 and `stop_n` stays 0 until `frame_n` is sampled 1, and no further data is accepted.
- R9: After the final phase completes with `frame_n` at 1, `devsel_n`, `trdy_n` and `stop_n` are all 1 and `ad_oe` is 0 in the next cycle. The target accepts a new address phase one cycle later.
- R10: If `irdy_n` is sampled 1 on `IRDY_LIMIT` (default 8) consecutive edges while `trdy_n` is 0, `proto_err` becomes 1. It stays 1 until the next address phase. Seven such edges leave it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Transaction in progress, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address in the address phase, write data in data phases |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target drives the shared lines |
| devsel_n | output | 1 | Target has claimed the transaction, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests the end of the burst, active low |
| proto_err | output | 1 | Initiator-ready wait exceeded the limit |

## Verification
The address cycle is cycle 0. For a hit, the claim shows in cycle 2. A write's ready strobe also shows in cycle 2. A read's ready strobe and output enable show in cycle 3, after the idle turnaround in cycle 2. The strobes are released in the cycle after the final phase. The bench plays the initiator: it drives every input on the falling edge and reads every output on the following falling edge, half a cycle after the rising edge that set it. It records the cycle number of each first assertion and compares it with these fixed offsets. The error flag is set on the edge of the eighth waiting cycle, so the bench reads it only after the transaction has ended and before the next address phase can clear it.

// File: rtl/bus_target_pkg.sv
package bus_target_pkg;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_TURN,
        ST_DATA,
        ST_BACKOFF,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic [29:0] word;
        logic [3:0]  cmd;
    } addr_phase_t;

    function automatic logic is_mem_cmd(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

endpackage

// File: rtl/bt_window_decode.sv
module bt_window_decode
    import bus_target_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h0000_4000,
    parameter int          OFF_W    = 2
) (
    input  addr_phase_t      ap,
    output logic             hit,
    output logic             is_read,
    output logic [OFF_W-1:0] off
);
    always_comb begin
        hit     = (ap.word[29:OFF_W] == WIN_BASE[31:OFF_W+2]) && is_mem_cmd(ap.cmd);
        is_read = (ap.cmd == CMD_MEM_RD);
        off     = ap.word[OFF_W-1:0];
    end
endmodule

// File: rtl/bt_regfile.sv
module bt_regfile #(
    parameter int WORDS = 4,
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFF_W-1:0] waddr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic [OFF_W-1:0] raddr,
    output logic [31:0]      rdata
);
    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++) lane[i] <= '0;
            end else if (we && be[b]) begin
                lane[waddr] <= wdata[8*b +: 8];
            end
        end

        assign rdata[8*b +: 8] = lane[raddr];
    end
endmodule

// File: rtl/bt_irdy_watch.sv
module bt_irdy_watch #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic waiting,
    input  logic moved,
    output logic err
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (moved) begin
            cnt <= '0;
        end else if (waiting) begin
            if (int'(cnt) == LIMIT - 1) err <= 1'b1;
            else                        cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bus_target_ctrl.sv
module bus_target_ctrl
    import bus_target_pkg::*;
#(
    parameter logic [31:0] WIN_BASE   = 32'h0000_4000,
    parameter int          WIN_BYTES  = 16,
    parameter int          MAX_BURST  = 3,
    parameter int          IRDY_LIMIT = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        proto_err
);
    localparam int WORDS  = WIN_BYTES / 4;
    localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int BEAT_W = $clog2(MAX_BURST + 1);
    localparam logic STOP_FIRST = (MAX_BURST == 1) ? 1'b0 : 1'b1;

    tgt_state_e        state;
    addr_phase_t       ap;
    logic [OFF_W-1:0]  off;
    logic [BEAT_W-1:0] beats;

    logic              dec_hit, dec_rd;
    logic [OFF_W-1:0]  dec_off;
    logic              xfer;
    logic [OFF_W-1:0]  raddr;
    logic [31:0]       rdata;

    bt_window_decode #(.WIN_BASE(WIN_BASE), .OFF_W(OFF_W)) u_dec (
        .ap      (ap),
        .hit     (dec_hit),
        .is_read (dec_rd),
        .off     (dec_off)
    );

    assign xfer  = (state == ST_DATA) && !trdy_n && !irdy_n;
    assign raddr = (state == ST_DATA) ? off + OFF_W'(1) : off;

    bt_regfile #(.WORDS(WORDS), .OFF_W(OFF_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (xfer && !dec_rd),
        .waddr (off),
        .be    (~cbe_n),
        .wdata (ad_in),
        .raddr (raddr),
        .rdata (rdata)
    );

    bt_irdy_watch #(.LIMIT(IRDY_LIMIT)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .clear   ((state == ST_IDLE) && !frame_n),
        .waiting ((state == ST_DATA) && !trdy_n && irdy_n),
        .moved   (xfer),
        .err     (proto_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ap       <= '0;
            off      <= '0;
            beats    <= '0;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
            ad_out   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!frame_n) begin
                        ap    <= '{word: ad_in[31:2], cmd: cbe_n};
                        state <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (dec_hit) begin
                        devsel_n <= 1'b0;
                        off      <= dec_off;
                        beats    <= '0;
                        if (dec_rd) begin
                            state <= ST_TURN;
                        end else begin
                            trdy_n <= 1'b0;
                            stop_n <= STOP_FIRST;
                            state  <= ST_DATA;
                        end
                    end else begin
                        state <= ST_SKIP;
                    end
                end
                ST_TURN: begin
                    ad_oe  <= 1'b1;
                    ad_out <= rdata;
                    trdy_n <= 1'b0;
                    stop_n <= STOP_FIRST;
                    state  <= ST_DATA;
                end
                ST_DATA: begin
                    if (xfer) begin
                        if (frame_n) begin
                            devsel_n <= 1'b1;
                            trdy_n   <= 1'b1;
                            stop_n   <= 1'b1;
                            ad_oe    <= 1'b0;
                            state    <= ST_IDLE;
                        end else if (!stop_n) begin
                            trdy_n <= 1'b1;
                            ad_oe  <= 1'b0;
                            state  <= ST_BACKOFF;
                        end else begin
                            off    <= off + OFF_W'(1);
                            beats  <= beats + 1'b1;
                            ad_out <= rdata;
                            if (int'(beats) + 1 == MAX_BURST - 1) stop_n <= 1'b0;
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (frame_n) begin
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_SKIP: begin
                    if (frame_n && irdy_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_target_ctrl_chk.sv
module bus_target_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic ad_oe,
    input logic proto_err
);
    // R4
    trdy_needs_claim_chk: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n);

    // R8
    stop_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stop_n) |-> !trdy_n);

    // R8
    no_data_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!stop_n && !trdy_n && !irdy_n) |=> trdy_n);

    // R5
    turnaround_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ad_oe) |-> $past(!devsel_n && trdy_n));

    // R9
    release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n && !ad_oe));

    // R10
    err_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> $past(irdy_n && !trdy_n));
endmodule

bind bus_target_ctrl bus_target_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n),
    .ad_oe     (ad_oe),
    .proto_err (proto_err)
);

// File: tb/bus_target_ctrl_tb.sv
module bus_target_ctrl_tb;
    localparam logic [31:0] BASE  = 32'h0000_4000;
    localparam logic [3:0]  C_RD  = 4'b0110;
    localparam logic [3:0]  C_WR  = 4'b0111;
    localparam logic [3:0]  C_IOW = 4'b0011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, proto_err;

    int total = 0;
    int bad = 0;

    logic [31:0] wdat [8];
    logic [3:0]  wbe  [8];
    logic [31:0] rdat [8];
    logic [31:0] model [4];
    int  beats_got, dev_at, trdy_at, oe_at;
    bit  saw_stop;

    always #4 clk = ~clk;

    bus_target_ctrl u_dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input int offs, input logic [31:0] d, input logic [3:0] be);
        for (int b = 0; b < 4; b++)
            if (be[b]) model[offs % 4][8*b +: 8] = d[8*b +: 8];
    endtask

    // Initiator model: drives on falling edges, observes outputs on falling edges.
    task automatic bus_xfer(input bit rd, input logic [3:0] cmd, input logic [31:0] addr,
                            input int n, input int dly);
        int  cyc;
        bit  done, started, abort, xfer_now, stop_now;
        beats_got = 0; dev_at = -1; trdy_at = -1; oe_at = -1; saw_stop = 0;
        done = 0; started = 0; abort = 0;
        @(negedge clk);
        cyc = 0; frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        cyc = 1; cbe_n = rd ? 4'h0 : ~wbe[0]; ad_in = rd ? '0 : wdat[0];
        if (dly == 0) begin irdy_n = 1'b0; frame_n = (n == 1); started = 1; end
        for (int k = 0; k < 60 && !done; k++) begin
            if (!devsel_n && dev_at < 0) dev_at = cyc;
            if (!trdy_n && trdy_at < 0) trdy_at = cyc;
            if (ad_oe && oe_at < 0) oe_at = cyc;
            xfer_now = !irdy_n && !trdy_n;
            stop_now = !stop_n;
            if (xfer_now) begin
                if (rd) rdat[beats_got] = ad_out;
                if (stop_now) saw_stop = 1;
                beats_got++;
            end
            @(negedge clk);
            cyc++;
            if (frame_n && (xfer_now || stop_now || abort)) begin
                irdy_n = 1'b1; done = 1;
            end else if (xfer_now && stop_now) begin
                frame_n = 1'b1;
            end else if (xfer_now) begin
                ad_in   = rd ? '0 : wdat[beats_got];
                cbe_n   = rd ? 4'h0 : ~wbe[beats_got];
                frame_n = (beats_got == n - 1);
            end else if (!started && cyc >= 1 + dly) begin
                irdy_n = 1'b0; frame_n = (n == 1); started = 1;
            end else if (started && dev_at < 0 && cyc >= 6 && !abort) begin
                frame_n = 1'b1; abort = 1;
            end
        end
        cbe_n = 4'hF;
    endtask

    task automatic t_reset;
        chk("R1", "devsel_n", devsel_n, 1);
        chk("R1", "trdy_n", trdy_n, 1);
        chk("R1", "stop_n", stop_n, 1);
        chk("R1", "ad_oe", ad_oe, 0);
        chk("R1", "proto_err", proto_err, 0);
    endtask

    task automatic t_single;
        wdat[0] = 32'h1234_5678; wbe[0] = 4'hF;
        bus_xfer(0, C_WR, BASE, 1, 0);
        model_write(0, wdat[0], 4'hF);
        chk("R2", "write claim cycle", dev_at, 2);
        chk("R4", "write ready cycle", trdy_at, 2);
        chk("R4", "write beats", beats_got, 1);
        chk("R9", "devsel released", devsel_n, 1);
        chk("R9", "trdy released", trdy_n, 1);
        bus_xfer(1, C_RD, BASE, 1, 0);
        chk("R2", "read claim cycle", dev_at, 2);
        chk("R5", "read ready cycle", trdy_at, 3);
        chk("R5", "read drive cycle", oe_at, 3);
        chk("R5", "read data", rdat[0], model[0]);
        chk("R9", "oe released", ad_oe, 0);
    endtask

    task automatic t_burst;
        for (int i = 0; i < 3; i++) begin wdat[i] = 32'hA0A0_0001 + i; wbe[i] = 4'hF; end
        bus_xfer(0, C_WR, BASE + 4, 3, 0);
        for (int i = 0; i < 3; i++) model_write(1 + i, wdat[i], 4'hF);
        chk("R8", "stop on limit phase", saw_stop, 1);
        chk("R4", "burst beats", beats_got, 3);
        bus_xfer(1, C_RD, BASE + 4, 3, 0);
        for (int i = 0; i < 3; i++) chk("R7", "burst read word", rdat[i], model[1 + i]);
    endtask

    task automatic t_disconnect;
        for (int i = 0; i < 4; i++) begin wdat[i] = 32'hB0B0_0000 + i; wbe[i] = 4'hF; end
        bus_xfer(0, C_WR, BASE, 4, 0);
        for (int i = 0; i < 3; i++) model_write(i, wdat[i], 4'hF);
        chk("R8", "beats before disconnect", beats_got, 3);
        chk("R8", "disconnect seen", saw_stop, 1);
        chk("R8", "stop released", stop_n, 1);
        bus_xfer(1, C_RD, BASE + 12, 1, 0);
        chk("R8", "word after limit untouched", rdat[0], model[3]);
        bus_xfer(1, C_RD, BASE, 1, 0);
        chk("R8", "first disconnected word", rdat[0], model[0]);
    endtask

    task automatic t_byte_enable;
        wdat[0] = 32'hAABB_CCDD; wbe[0] = 4'hF;
        bus_xfer(0, C_WR, BASE + 8, 1, 0);
        model_write(2, wdat[0], 4'hF);
        wdat[0] = 32'h1122_3344; wbe[0] = 4'b0101;
        bus_xfer(0, C_WR, BASE + 8, 1, 0);
        model_write(2, wdat[0], 4'b0101);
        bus_xfer(1, C_RD, BASE + 8, 1, 0);
        chk("R6", "merged bytes", rdat[0], 32'hAA22_CC44);
    endtask

    task automatic t_addr_bits;
        bus_xfer(1, C_RD, BASE + 6, 1, 0);
        chk("R7", "low bits ignored", rdat[0], model[1]);
        wdat[0] = 32'hC3C3_0003; wdat[1] = 32'hC0C0_0000; wbe[0] = 4'hF; wbe[1] = 4'hF;
        bus_xfer(0, C_WR, BASE + 12, 2, 0);
        model_write(3, wdat[0], 4'hF);
        model_write(4, wdat[1], 4'hF);
        bus_xfer(1, C_RD, BASE, 1, 0);
        chk("R7", "wrap to word 0", rdat[0], model[0]);
    endtask

    task automatic t_ignore;
        wdat[0] = 32'hDEAD_BEEF; wbe[0] = 4'hF;
        bus_xfer(0, C_IOW, BASE, 1, 0);
        chk("R3", "io command not claimed", dev_at, 32'hFFFF_FFFF);
        chk("R3", "io command no ready", trdy_at, 32'hFFFF_FFFF);
        bus_xfer(0, C_WR, BASE + 16, 1, 0);
        chk("R3", "outside window not claimed", dev_at, 32'hFFFF_FFFF);
        bus_xfer(1, C_RD, BASE, 1, 0);
        chk("R3", "word unchanged", rdat[0], model[0]);
    endtask

    task automatic t_timeout;
        wdat[0] = 32'h5555_0000; wbe[0] = 4'hF;
        bus_xfer(0, C_WR, BASE, 1, 8);
        model_write(0, wdat[0], 4'hF);
        chk("R10", "seven waits no error", proto_err, 0);
        bus_xfer(0, C_WR, BASE, 1, 9);
        chk("R10", "eight waits flag", proto_err, 1);
        @(negedge clk);
        chk("R10", "flag held after end", proto_err, 1);
        bus_xfer(1, C_RD, BASE, 1, 0);
        chk("R10", "flag cleared by new address", proto_err, 0);
        chk("R10", "slow write landed", rdat[0], model[0]);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_single;
        t_burst;
        t_disconnect;
        t_byte_enable;
        t_addr_bits;
        t_ignore;
        t_timeout;
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule